// File: doc/BRIEF.md
# MSI Event Queue Controller

This block turns message-signalled interrupt writes into entries of circular event queues that live in host memory. Each incoming MSI carries a vector number and a 16-bit data value. A steering table picks the queue for the vector. The controller then writes one 32-bit entry at the queue's current tail slot. It waits for the memory system to confirm that write, and only then moves the tail forward. Each queue has its own interrupt line. That line stays high for as long as the queue holds entries that software has not yet consumed.

Software works through a small register port. It sets a base address for each queue and reads back the tail pointer that the controller maintains. When it has finished with entries, it writes the head pointer. It can also re-steer any vector to a different queue, for example to move that vector's interrupts to another CPU. The controller holds one memory write in flight at a time. It stalls further MSIs with backpressure, and it also stalls any MSI whose target queue is full.

Top module: `msi_evq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every head and tail pointer reads 0. Every vector steers to queue 0, all `irq` bits are low, and `mem_wr_req` is low.
- R2: An entry is written to address `base[q] + 4*tail[q]`, where q is the queue the vector is steered to at the moment the MSI is accepted.
- R3: The entry word carries the MSI data in bits [15:0] and the vector number in bits [21:16]. Bits [31:22] are zero.
- R4: Once raised, `mem_wr_req` stays high with stable address and data until a cycle in which `mem_wr_ack` is high. The tail of the target queue advances by one in that same clock edge and at no other time. The tail wraps from 63 to 0.
- R5: `irq[q]` is high exactly while head[q] and tail[q] differ. It therefore rises only after an acknowledged write, and it falls once software writes head[q] equal to tail[q].
- R6: A queue is full when tail+1 equals head, modulo 64. While it is full, `msi_ready` is low for MSIs aimed at that queue and no write is issued. Acceptance resumes once software advances the head.
- R7: At most one memory write is outstanding. `msi_ready` is low while `mem_wr_req` is high, and MSIs are written in the order they were accepted.
- R8: Rewriting a vector's steering entry sends that vector's later MSIs to the new queue and raises that queue's interrupt instead.
- R9: Register address bits [7:6] select the register kind: 0 selects a queue base address (read/write), 1 a head pointer (read/write), 2 a tail pointer (read-only, so writes are ignored), and 3 a vector's steering entry (read/write, queue number in the low data bits). Bits [5:0] give the queue or vector index. `reg_rdata` reflects `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msi_valid | input | 1 | An MSI is offered |
| msi_vector | input | 6 | Vector number of the offered MSI |
| msi_data | input | 16 | Data value of the offered MSI |
| msi_ready | output | 1 | MSI accepted on a clock edge where valid and ready are both high |
| mem_wr_req | output | 1 | Entry write request, held until acknowledged |
| mem_wr_addr | output | 32 | Byte address of the entry |
| mem_wr_data | output | 32 | Entry word |
| mem_wr_ack | input | 1 | Write is complete in host memory |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register kind [7:6] and index [5:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 4 | One level interrupt per queue |

## Verification
The bench holds back the write acknowledge for several cycles. A design that advanced the tail or raised the interrupt on the request alone, rather than on the acknowledge, would show tail 1 and a high `irq` while the write is still pending. It fills one queue to 63 entries and then offers one more MSI. A design that ignored the full condition would overwrite the head slot, and one that wrapped the pointer wrongly would place the next entries anywhere but slot 63 and then slot 0. It offers two MSIs back to back against a slow memory and re-steers a vector between sends. A design that let a second write overlap the first, reordered the two, or cached the old steering would produce log entries at the wrong addresses or in the wrong order.

// File: rtl/msi_evq_pkg.sv
// Shared constants and types for the MSI event queue controller.
// Assumes a 32-bit entry word and a 16-bit MSI data value.
package msi_evq_pkg;
    localparam int MSI_DATA_W = 16;
    localparam int ENTRY_W    = 32;
    localparam int KIND_W     = 2;

    typedef enum logic [1:0] {
        RK_BASE  = 2'd0,
        RK_HEAD  = 2'd1,
        RK_TAIL  = 2'd2,
        RK_STEER = 2'd3
    } reg_kind_e;

    typedef enum logic {
        SQ_IDLE  = 1'b0,
        SQ_WRITE = 1'b1
    } seq_state_e;
endpackage

// File: rtl/msi_evq_steer.sv
// Vector-to-queue steering table.
// Holds one queue number per vector; it has one lookup port for the MSI path
// and one for register reads. Assumes NUM_VEC == 2**VEC_W.
module msi_evq_steer #(
    parameter int NUM_VEC = 64,
    parameter int VEC_W   = 6,
    parameter int QW      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VEC_W-1:0] wr_vec,
    input  logic [QW-1:0]    wr_q,
    input  logic [VEC_W-1:0] lk_vec,
    output logic [QW-1:0]    lk_q,
    input  logic [VEC_W-1:0] rd_vec,
    output logic [QW-1:0]    rd_q
);
    logic [QW-1:0] map_q [NUM_VEC];

    // Table update: clear to queue 0 on reset, rewrite one entry per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VEC; i++) map_q[i] <= '0;
        end else if (wr_en) begin
            map_q[wr_vec] <= wr_q;
        end
    end

    assign lk_q = map_q[lk_vec];
    assign rd_q = map_q[rd_vec];
endmodule

// File: rtl/msi_evq_qbank.sv
// Per-queue state: base address, head (software-owned), tail (controller-owned).
// Derives the full flag and the level interrupt of each queue.
// Assumes the depth is 2**PTR_W, so the pointers wrap naturally.
module msi_evq_qbank #(
    parameter int NUM_Q  = 4,
    parameter int PTR_W  = 6,
    parameter int ADDR_W = 32,
    parameter int QW     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    base_we,
    input  logic                    head_we,
    input  logic [QW-1:0]           wr_q,
    input  logic [ADDR_W-1:0]       wr_data,
    input  logic                    adv,
    input  logic [QW-1:0]           adv_q,
    output logic [NUM_Q*ADDR_W-1:0] base_flat,
    output logic [NUM_Q*PTR_W-1:0]  head_flat,
    output logic [NUM_Q*PTR_W-1:0]  tail_flat,
    output logic [NUM_Q-1:0]        full,
    output logic [NUM_Q-1:0]        irq
);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        logic [ADDR_W-1:0] base_r;
        logic [PTR_W-1:0]  head_r;
        logic [PTR_W-1:0]  tail_r;
        logic [PTR_W-1:0]  tail_nx;

        // Base address register, written by software.
        always_ff @(posedge clk) begin
            if (!rst_n)                           base_r <= '0;
            else if (base_we && wr_q == QW'(g))   base_r <= wr_data;
        end

        // Head pointer, written by software after it consumes entries.
        always_ff @(posedge clk) begin
            if (!rst_n)                           head_r <= '0;
            else if (head_we && wr_q == QW'(g))   head_r <= wr_data[PTR_W-1:0];
        end

        // Tail pointer, advanced only when an entry write is acknowledged.
        always_ff @(posedge clk) begin
            if (!rst_n)                           tail_r <= '0;
            else if (adv && adv_q == QW'(g))      tail_r <= tail_nx;
        end

        assign tail_nx = tail_r + PTR_ONE;
        assign full[g] = (tail_nx == head_r);
        assign irq[g]  = (head_r != tail_r);
        assign base_flat[g*ADDR_W +: ADDR_W] = base_r;
        assign head_flat[g*PTR_W +: PTR_W]   = head_r;
        assign tail_flat[g*PTR_W +: PTR_W]   = tail_r;
    end
endmodule

// File: rtl/msi_evq_seq.sv
// Write sequencer: accepts one MSI, formats the entry, and holds the memory
// request until it is acknowledged, then tells the queue bank to advance
// the tail. Only one write is in flight; further MSIs see ready low.
module msi_evq_seq
    import msi_evq_pkg::*;
#(
    parameter int NUM_Q  = 4,
    parameter int PTR_W  = 6,
    parameter int ADDR_W = 32,
    parameter int QW     = 2,
    parameter int VEC_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    msi_valid,
    input  logic [VEC_W-1:0]        msi_vector,
    input  logic [MSI_DATA_W-1:0]   msi_data,
    output logic                    msi_ready,
    input  logic [QW-1:0]           tgt_q,
    input  logic [NUM_Q-1:0]        full,
    input  logic [NUM_Q*ADDR_W-1:0] base_flat,
    input  logic [NUM_Q*PTR_W-1:0]  tail_flat,
    output logic                    mem_wr_req,
    output logic [ADDR_W-1:0]       mem_wr_addr,
    output logic [ENTRY_W-1:0]      mem_wr_data,
    input  logic                    mem_wr_ack,
    output logic                    adv,
    output logic [QW-1:0]           adv_q
);
    localparam int PAD_W = ENTRY_W - MSI_DATA_W - VEC_W;

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ENTRY_W-1:0] data_q;
    logic [QW-1:0]     q_q;
    logic [ADDR_W-1:0] slot_addr;
    logic [PTR_W-1:0]  tgt_tail;
    logic              accept;

    assign tgt_tail  = tail_flat[tgt_q*PTR_W +: PTR_W];
    assign slot_addr = base_flat[tgt_q*ADDR_W +: ADDR_W] + ADDR_W'({tgt_tail, 2'b00});
    assign msi_ready = (state_q == SQ_IDLE) && !full[tgt_q];
    assign accept    = msi_valid && msi_ready;

    // Capture the entry on acceptance; return to idle on the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            q_q     <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (accept) begin
                    addr_q  <= slot_addr;
                    data_q  <= {{PAD_W{1'b0}}, msi_vector, msi_data};
                    q_q     <= tgt_q;
                    state_q <= SQ_WRITE;
                end
                SQ_WRITE: if (mem_wr_ack) state_q <= SQ_IDLE;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign mem_wr_req  = (state_q == SQ_WRITE);
    assign mem_wr_addr = addr_q;
    assign mem_wr_data = data_q;
    assign adv         = mem_wr_req && mem_wr_ack;
    assign adv_q       = q_q;
endmodule

// File: rtl/msi_evq_ctrl.sv
// MSI event queue controller top level.
// Connects the steering table, queue bank and write sequencer, and decodes
// the register port. Assumes NUM_Q <= NUM_VEC and power-of-two counts.
module msi_evq_ctrl
    import msi_evq_pkg::*;
#(
    parameter int NUM_Q   = 4,
    parameter int NUM_VEC = 64,
    parameter int Q_DEPTH = 64,
    parameter int ADDR_W  = 32,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int REG_AW = KIND_W + VEC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  msi_valid,
    input  logic [VEC_W-1:0]      msi_vector,
    input  logic [MSI_DATA_W-1:0] msi_data,
    output logic                  msi_ready,
    output logic                  mem_wr_req,
    output logic [ADDR_W-1:0]     mem_wr_addr,
    output logic [ENTRY_W-1:0]    mem_wr_data,
    input  logic                  mem_wr_ack,
    input  logic                  reg_wr_en,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [ADDR_W-1:0]     reg_wdata,
    output logic [ADDR_W-1:0]     reg_rdata,
    output logic [NUM_Q-1:0]      irq
);
    localparam int PTR_W = $clog2(Q_DEPTH);
    localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

    reg_kind_e                kind;
    logic [VEC_W-1:0]         idx;
    logic [QW-1:0]            rq;
    logic                     idx_ok;
    logic [NUM_Q*ADDR_W-1:0]  base_flat;
    logic [NUM_Q*PTR_W-1:0]   head_flat;
    logic [NUM_Q*PTR_W-1:0]   tail_flat;
    logic [NUM_Q-1:0]         full;
    logic [QW-1:0]            tgt_q;
    logic [QW-1:0]            steer_rd_q;
    logic                     adv;
    logic [QW-1:0]            adv_q;

    assign kind   = reg_kind_e'(reg_addr[REG_AW-1 -: KIND_W]);
    assign idx    = reg_addr[VEC_W-1:0];
    assign rq     = idx[QW-1:0];
    assign idx_ok = (32'(idx) < 32'(NUM_Q));

    msi_evq_steer #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .QW(QW)) steer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en && kind == RK_STEER),
        .wr_vec (idx),
        .wr_q   (reg_wdata[QW-1:0]),
        .lk_vec (msi_vector),
        .lk_q   (tgt_q),
        .rd_vec (idx),
        .rd_q   (steer_rd_q)
    );

    msi_evq_qbank #(.NUM_Q(NUM_Q), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .QW(QW)) qbank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_we   (reg_wr_en && kind == RK_BASE && idx_ok),
        .head_we   (reg_wr_en && kind == RK_HEAD && idx_ok),
        .wr_q      (rq),
        .wr_data   (reg_wdata),
        .adv       (adv),
        .adv_q     (adv_q),
        .base_flat (base_flat),
        .head_flat (head_flat),
        .tail_flat (tail_flat),
        .full      (full),
        .irq       (irq)
    );

    msi_evq_seq #(.NUM_Q(NUM_Q), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .QW(QW), .VEC_W(VEC_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .msi_valid   (msi_valid),
        .msi_vector  (msi_vector),
        .msi_data    (msi_data),
        .msi_ready   (msi_ready),
        .tgt_q       (tgt_q),
        .full        (full),
        .base_flat   (base_flat),
        .tail_flat   (tail_flat),
        .mem_wr_req  (mem_wr_req),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .mem_wr_ack  (mem_wr_ack),
        .adv         (adv),
        .adv_q       (adv_q)
    );

    // Register read mux; out-of-range queue indices read as zero.
    always_comb begin
        reg_rdata = '0;
        case (kind)
            RK_BASE:  if (idx_ok) reg_rdata = base_flat[rq*ADDR_W +: ADDR_W];
            RK_HEAD:  if (idx_ok) reg_rdata = ADDR_W'(head_flat[rq*PTR_W +: PTR_W]);
            RK_TAIL:  if (idx_ok) reg_rdata = ADDR_W'(tail_flat[rq*PTR_W +: PTR_W]);
            RK_STEER: reg_rdata = ADDR_W'(steer_rd_q);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/msi_evq_ctrl_chk.sv
// Protocol and ordering checker for msi_evq_ctrl, attached by bind.
// Observes the ports plus the tail pointers inside the top level.
module msi_evq_ctrl_chk #(
    parameter int NUM_Q  = 4,
    parameter int PTR_W  = 6,
    parameter int ADDR_W = 32,
    parameter int REG_AW = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   msi_ready,
    input logic                   mem_wr_req,
    input logic                   mem_wr_ack,
    input logic [ADDR_W-1:0]      mem_wr_addr,
    input logic [31:0]            mem_wr_data,
    input logic                   reg_wr_en,
    input logic [REG_AW-1:0]      reg_addr,
    input logic [NUM_Q-1:0]       irq,
    input logic [NUM_Q*PTR_W-1:0] tail_flat
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq == '0 && !mem_wr_req)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req && !mem_wr_ack |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)); // R4

    AST_TAIL_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tail_flat) |-> $past(mem_wr_req && mem_wr_ack)); // R4

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        |(irq & ~$past(irq)) |-> ($past(mem_wr_req && mem_wr_ack)
                                  || $past(reg_wr_en && reg_addr[REG_AW-1 -: 2] == 2'd1))); // R5

    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> !msi_ready); // R7
endmodule

bind msi_evq_ctrl msi_evq_ctrl_chk #(
    .NUM_Q(NUM_Q), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .msi_ready   (msi_ready),
    .mem_wr_req  (mem_wr_req),
    .mem_wr_ack  (mem_wr_ack),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .irq         (irq),
    .tail_flat   (tail_flat)
);

// File: tb/msi_evq_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench for msi_evq_ctrl: one task per scenario, each checking itself.
module msi_evq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0;
    logic [5:0]  msi_vector = '0;
    logic [15:0] msi_data = '0;
    logic        msi_ready;
    logic        mem_wr_req;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        mem_wr_ack = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq;

    int n_checks = 0;
    int n_fails  = 0;
    int ack_delay = 2;
    int log_n = 0;
    logic [31:0] log_addr [256];
    logic [31:0] log_data [256];

    always #4 clk = ~clk;

    msi_evq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .msi_valid(msi_valid), .msi_vector(msi_vector), .msi_data(msi_data), .msi_ready(msi_ready),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ack(mem_wr_ack),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    // Host memory model: logs each request, acknowledges after ack_delay cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_wr_req) begin
                log_addr[log_n % 256] = mem_wr_addr;
                log_data[log_n % 256] = mem_wr_data;
                log_n++;
                repeat (ack_delay) @(negedge clk);
                mem_wr_ack = 1'b1;
                @(negedge clk);
                mem_wr_ack = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] kind, input logic [5:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_addr = {kind, idx}; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] kind, input logic [5:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_addr = {kind, idx};
        #1 d = reg_rdata;
    endtask

    // Waits (valid already high) until accepted, then drops valid.
    task automatic wait_accept();
        for (int i = 0; i < 400; i++) begin
            #1;
            if (msi_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1 msi_valid = 1'b0;
    endtask

    task automatic send_msi(input logic [5:0] vec, input logic [15:0] d);
        @(negedge clk);
        msi_vector = vec; msi_data = d; msi_valid = 1'b1;
        wait_accept();
    endtask

    task automatic settle();
        repeat (ack_delay + 4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        chk("R1 irq", {28'd0, irq}, 32'd0);
        chk("R1 req", {31'd0, mem_wr_req}, 32'd0);
        reg_rd(2'd2, 6'd2, v); chk("R1 tail2", v, 32'd0);
        reg_rd(2'd1, 6'd3, v); chk("R1 head3", v, 32'd0);
        reg_rd(2'd3, 6'd37, v); chk("R1 steer37", v, 32'd0);
        reg_rd(2'd3, 6'd63, v); chk("R1 steer63", v, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        reg_wr(2'd0, 6'd0, 32'h1000_0000);
        reg_wr(2'd0, 6'd1, 32'h2000_0000);
        reg_wr(2'd0, 6'd2, 32'h3000_0100);
        reg_wr(2'd0, 6'd3, 32'h4000_0000);
        reg_rd(2'd0, 6'd2, v); chk("R9 base2", v, 32'h3000_0100);
        reg_wr(2'd2, 6'd0, 32'd5);
        reg_rd(2'd2, 6'd0, v); chk("R9 tail read-only", v, 32'd0);
        reg_wr(2'd3, 6'd5, 32'd2);
        reg_wr(2'd3, 6'd9, 32'd1);
        reg_rd(2'd3, 6'd5, v); chk("R9 steer5", v, 32'd2);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        ack_delay = 3;
        send_msi(6'd5, 16'hBEEF);
        @(negedge clk);
        chk("R4 req pending", {31'd0, mem_wr_req}, 32'd1);
        chk("R2 addr", mem_wr_addr, 32'h3000_0100);
        chk("R3 data", mem_wr_data, 32'h0005_BEEF);
        chk("R5 irq before ack", {28'd0, irq}, 32'd0);
        #1 reg_addr = {2'd2, 6'd2}; #1 chk("R4 tail before ack", reg_rdata, 32'd0);
        settle();
        chk("R4 req done", {31'd0, mem_wr_req}, 32'd0);
        reg_rd(2'd2, 6'd2, v); chk("R4 tail advanced", v, 32'd1);
        chk("R5 irq after ack", {28'd0, irq}, 32'b0100);
        send_msi(6'd5, 16'h1234);
        settle();
        chk("R2 second addr", log_addr[(log_n - 1) % 256], 32'h3000_0104);
        reg_wr(2'd1, 6'd2, 32'd2);
        @(negedge clk);
        chk("R5 irq cleared", {28'd0, irq}, 32'd0);
    endtask

    task automatic t_steer();
        ack_delay = 1;
        send_msi(6'd7, 16'h0042);
        settle();
        chk("R8 default queue addr", log_addr[(log_n - 1) % 256], 32'h1000_0000);
        chk("R8 irq0", {28'd0, irq}, 32'b0001);
        reg_wr(2'd1, 6'd0, 32'd1);
        reg_wr(2'd3, 6'd5, 32'd3);
        send_msi(6'd5, 16'h0777);
        settle();
        chk("R8 remapped addr", log_addr[(log_n - 1) % 256], 32'h4000_0000);
        chk("R8 remapped irq", {28'd0, irq}, 32'b1000);
        reg_wr(2'd1, 6'd3, 32'd1);
    endtask

    task automatic t_order();
        int base_n;
        ack_delay = 4;
        base_n = log_n;
        send_msi(6'd7, 16'hAAAA);
        @(negedge clk);
        msi_vector = 6'd20; msi_data = 16'h5555; msi_valid = 1'b1;
        #1 chk("R7 ready low while busy", {31'd0, msi_ready}, 32'd0);
        wait_accept();
        settle();
        chk("R7 count", 32'(log_n - base_n), 32'd2);
        chk("R7 first", log_addr[base_n % 256], 32'h1000_0004);
        chk("R7 second", log_addr[(base_n + 1) % 256], 32'h1000_0008);
        chk("R3 second data", log_data[(base_n + 1) % 256], 32'h0014_5555);
        reg_wr(2'd1, 6'd0, 32'd3);
    endtask

    task automatic t_full_wrap();
        logic [31:0] v;
        int base_n;
        ack_delay = 0;
        for (int i = 0; i < 63; i++) begin
            send_msi(6'd9, 16'(i));
            settle();
        end
        reg_rd(2'd2, 6'd1, v); chk("R6 tail at 63", v, 32'd63);
        base_n = log_n;
        @(negedge clk);
        msi_vector = 6'd9; msi_data = 16'hF00D; msi_valid = 1'b1;
        repeat (5) @(negedge clk);
        #1 chk("R6 ready low when full", {31'd0, msi_ready}, 32'd0);
        chk("R6 no write when full", 32'(log_n - base_n), 32'd0);
        reg_wr(2'd1, 6'd1, 32'd63);
        wait_accept();
        settle();
        chk("R4 slot 63 addr", log_addr[(log_n - 1) % 256], 32'h2000_00FC);
        chk("R3 slot 63 data", log_data[(log_n - 1) % 256], 32'h0009_F00D);
        reg_rd(2'd2, 6'd1, v); chk("R4 tail wrapped", v, 32'd0);
        send_msi(6'd9, 16'h0001);
        settle();
        chk("R4 slot 0 addr", log_addr[(log_n - 1) % 256], 32'h2000_0000);
        chk("R5 irq1 across wrap", {28'd0, irq}, 32'b0010);
        reg_wr(2'd1, 6'd1, 32'd1);
        @(negedge clk);
        chk("R5 irq1 cleared", {28'd0, irq}, 32'd0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_basic();
        t_steer();
        t_order();
        t_full_wrap();
        finish_run();
    end
endmodule